// File: doc/BRIEF.md
# Vector CSR Access Unit

This block keeps the architectural control and status state of a vector unit: the vector length, the vector type, the start element index, the fixed-point rounding mode and the fixed-point saturation flag. The vector register byte length is also visible as a constant. The scalar pipeline sends it CSR instructions one at a time. Each instruction names an operation (write, set bits, clear bits), a source (a register value or a 5-bit immediate) and a 12-bit CSR address. The unit answers each one with the value the CSR held before the instruction, or with an illegal-instruction flag.

Length and type are computed by the configuration instructions elsewhere. Their results reach this block through a separate configuration write port. Through the CSR path, only the start index, rounding mode and saturation flag can be changed. The other registers are read-only, and an attempt to change them is refused with an exception.

Every accepted instruction is held until the vector backend reports that it is idle. Only then is the instruction completed, so that no CSR changes under an instruction that is still running.

Top module: `vcsr_unit`

## Requirements
- R1: After reset, all stored CSRs read zero, `req_ready_o` is high and `resp_valid_o` is low.
- R2: The operation code `req_op_i` is 1 = write, 2 = set, 3 = clear (register source `req_src_i`), and 5 = write, 6 = set, 7 = clear (zero-extended immediate `req_imm_i`). The new value is the operand for a write, old OR operand for a set, and old AND NOT operand for a clear.
- R3: A legal response carries the value the addressed CSR held before the instruction, zero-extended to XLEN.
- R4: Only the start index (0x008), saturation flag (0x009) and rounding mode (0x00A) are writable. Stored values are truncated: the start index to log2(VLEN) bits, the rounding mode to 2 bits and the saturation flag to 1 bit.
- R5: Vector length (0xC20), vector type (0xC21) and byte length (0xC22) are read-only. A write-form operation on them, or a set or clear with a non-zero operand, is illegal and leaves all state unchanged.
- R6: A set or clear whose operand is zero is a pure read. It is legal on the read-only CSRs.
- R7: An unknown address, or operation code 0 or 4, is illegal. The response then carries `resp_rdata_o` = 0 and no CSR changes.
- R8: A request is accepted only while `req_ready_o` is high. After acceptance `req_ready_o` stays low. The single-cycle response is raised in the first cycle in which `backend_idle_i` is high, and never before.
- R9: A pulse on `cfg_we_i` loads `cfg_vl_i` and `cfg_vtype_i` into the length and type registers, where CSR reads see them.
- R10: The byte length CSR reads VLEN/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | CSR instruction offered |
| req_ready_o | output | 1 | Unit free to take an instruction |
| req_op_i | input | 3 | Operation code (see R2) |
| req_addr_i | input | 12 | CSR address |
| req_src_i | input | XLEN | Register-source operand |
| req_imm_i | input | 5 | Immediate operand |
| backend_idle_i | input | 1 | Vector backend has no work in flight |
| resp_valid_o | output | 1 | Response pulse |
| resp_illegal_o | output | 1 | Instruction raised illegal-instruction |
| resp_rdata_o | output | XLEN | Old CSR value |
| cfg_we_i | input | 1 | Load length and type |
| cfg_vl_i | input | log2(VLEN)+1 | New vector length |
| cfg_vtype_i | input | XLEN | New vector type |

## Verification
Writes, sets and clears are driven in both source forms with operands that have bits above the stored width. This separates correct truncation from a full-width store, and a set from a clear. Each read-only CSR gets both a zero and a non-zero set/clear operand, followed by a read-back, which separates the pure-read exemption from a refused write that still changes state. The backend-idle delay is varied from zero to several cycles, which shows whether the response waits for idle or fires early.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;

  localparam logic [11:0] ADDR_VSTART = 12'h008;
  localparam logic [11:0] ADDR_VXSAT  = 12'h009;
  localparam logic [11:0] ADDR_VXRM   = 12'h00A;
  localparam logic [11:0] ADDR_VL     = 12'hC20;
  localparam logic [11:0] ADDR_VTYPE  = 12'hC21;
  localparam logic [11:0] ADDR_VLENB  = 12'hC22;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_VSTART, SEL_VXSAT, SEL_VXRM, SEL_VL, SEL_VTYPE, SEL_VLENB
  } csr_sel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT} unit_state_e;

  // codes 0 and 4 are reserved
  function automatic logic op_defined(logic [2:0] op);
    return op[1:0] != 2'b00;
  endfunction

  // write form always modifies; set/clear modify only with a non-zero operand
  function automatic logic op_modifies(logic [2:0] op, logic [63:0] opnd);
    return (op[1:0] == 2'b01) || (opnd != 64'd0);
  endfunction

  function automatic logic [63:0] op_merge(logic [2:0] op, logic [63:0] old,
                                           logic [63:0] opnd);
    case (op[1:0])
      2'b01:   return opnd;
      2'b10:   return old | opnd;
      2'b11:   return old & ~opnd;
      default: return old;
    endcase
  endfunction

  function automatic csr_sel_e addr_decode(logic [11:0] addr);
    case (addr)
      ADDR_VSTART: return SEL_VSTART;
      ADDR_VXSAT:  return SEL_VXSAT;
      ADDR_VXRM:   return SEL_VXRM;
      ADDR_VL:     return SEL_VL;
      ADDR_VTYPE:  return SEL_VTYPE;
      ADDR_VLENB:  return SEL_VLENB;
      default:     return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vcsr_decode.sv
module vcsr_decode
  import vcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      op_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [4:0]      imm_i,
  output csr_sel_e        sel_o,
  output logic [XLEN-1:0] operand_o,
  output logic            modifies_o,
  output logic            illegal_o
);
  logic read_only;

  always_comb begin
    operand_o  = op_i[2] ? XLEN'(imm_i) : src_i;
    sel_o      = addr_decode(addr_i);
    modifies_o = op_modifies(op_i, 64'(operand_o));
    read_only  = (sel_o == SEL_VL) || (sel_o == SEL_VTYPE) || (sel_o == SEL_VLENB);
    illegal_o  = !op_defined(op_i) || (sel_o == SEL_NONE) || (read_only && modifies_o);
  end
endmodule

// File: rtl/vcsr_regs.sv
module vcsr_regs
  import vcsr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int VSTART_W = 8,
  parameter int VL_W     = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  csr_sel_e            wr_sel_i,
  input  logic [VSTART_W-1:0] wr_vstart_i,
  input  logic [1:0]          wr_vxrm_i,
  input  logic                wr_vxsat_i,
  input  logic                cfg_we_i,
  input  logic [VL_W-1:0]     cfg_vl_i,
  input  logic [XLEN-1:0]     cfg_vtype_i,
  output logic [VSTART_W-1:0] vstart_o,
  output logic [1:0]          vxrm_o,
  output logic                vxsat_o,
  output logic [VL_W-1:0]     vl_o,
  output logic [XLEN-1:0]     vtype_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vstart_o <= '0;
      vxrm_o   <= '0;
      vxsat_o  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_VSTART) vstart_o <= wr_vstart_i;
      if (wr_sel_i == SEL_VXRM)   vxrm_o   <= wr_vxrm_i;
      if (wr_sel_i == SEL_VXSAT)  vxsat_o  <= wr_vxsat_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_o    <= '0;
      vtype_o <= '0;
    end else if (cfg_we_i) begin
      vl_o    <= cfg_vl_i;
      vtype_o <= cfg_vtype_i;
    end
  end

  AST_FIXED_STATE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(vstart_o) && $stable(vxrm_o) && $stable(vxsat_o))); // R7
  AST_CFG_STATE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(vl_o) && $stable(vtype_o))); // R5
endmodule

// File: rtl/vcsr_unit.sv
module vcsr_unit
  import vcsr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 256,
  localparam int VSTART_W = $clog2(VLEN),
  localparam int VL_W     = $clog2(VLEN) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [2:0]      req_op_i,
  input  logic [11:0]     req_addr_i,
  input  logic [XLEN-1:0] req_src_i,
  input  logic [4:0]      req_imm_i,
  input  logic            backend_idle_i,
  output logic            resp_valid_o,
  output logic            resp_illegal_o,
  output logic [XLEN-1:0] resp_rdata_o,
  input  logic            cfg_we_i,
  input  logic [VL_W-1:0] cfg_vl_i,
  input  logic [XLEN-1:0] cfg_vtype_i
);
  localparam logic [XLEN-1:0] VLENB_VAL = XLEN'(VLEN / 8);

  unit_state_e state_q;
  logic [2:0]      op_q;
  logic [11:0]     addr_q;
  logic [XLEN-1:0] src_q;
  logic [4:0]      imm_q;

  // named events for assertions
  logic accept, fire, wr_en;

  csr_sel_e        sel;
  logic [XLEN-1:0] operand, old_val, new_val;
  logic            modifies, illegal;

  logic [VSTART_W-1:0] vstart;
  logic [1:0]          vxrm;
  logic                vxsat;
  logic [VL_W-1:0]     vl;
  logic [XLEN-1:0]     vtype;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign fire        = (state_q == ST_WAIT) && backend_idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      imm_q   <= '0;
    end else if (accept) begin
      state_q <= ST_WAIT;
      op_q    <= req_op_i;
      addr_q  <= req_addr_i;
      src_q   <= req_src_i;
      imm_q   <= req_imm_i;
    end else if (fire) begin
      state_q <= ST_IDLE;
    end
  end

  vcsr_decode #(.XLEN(XLEN)) u_decode (
    .op_i       (op_q),
    .addr_i     (addr_q),
    .src_i      (src_q),
    .imm_i      (imm_q),
    .sel_o      (sel),
    .operand_o  (operand),
    .modifies_o (modifies),
    .illegal_o  (illegal)
  );

  always_comb begin
    case (sel)
      SEL_VSTART: old_val = XLEN'(vstart);
      SEL_VXSAT:  old_val = XLEN'(vxsat);
      SEL_VXRM:   old_val = XLEN'(vxrm);
      SEL_VL:     old_val = XLEN'(vl);
      SEL_VTYPE:  old_val = vtype;
      SEL_VLENB:  old_val = VLENB_VAL;
      default:    old_val = '0;
    endcase
    new_val = XLEN'(op_merge(op_q, 64'(old_val), 64'(operand)));
  end

  assign wr_en          = fire && !illegal && modifies;
  assign resp_valid_o   = fire;
  assign resp_illegal_o = illegal;
  assign resp_rdata_o   = illegal ? '0 : old_val;

  vcsr_regs #(.XLEN(XLEN), .VSTART_W(VSTART_W), .VL_W(VL_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_sel_i    (sel),
    .wr_vstart_i (VSTART_W'(new_val)),
    .wr_vxrm_i   (new_val[1:0]),
    .wr_vxsat_i  (new_val[0]),
    .cfg_we_i    (cfg_we_i),
    .cfg_vl_i    (cfg_vl_i),
    .cfg_vtype_i (cfg_vtype_i),
    .vstart_o    (vstart),
    .vxrm_o      (vxrm),
    .vxsat_o     (vxsat),
    .vl_o        (vl),
    .vtype_o     (vtype)
  );

  AST_RESP_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> backend_idle_i); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o); // R8
  AST_RESP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o); // R8
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_illegal_o) |-> !wr_en); // R7
  AST_ILLEGAL_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_illegal_o) |-> (resp_rdata_o == '0)); // R7
endmodule

// File: tb/sim_vcsr_unit.sv
module sim_vcsr_unit;
  localparam int XLEN = 32;
  localparam int VLEN = 256;
  localparam int VL_W = $clog2(VLEN) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [11:0] req_addr = '0;
  logic [XLEN-1:0] req_src = '0;
  logic [4:0] req_imm = '0;
  logic backend_idle = 1'b0;
  logic resp_valid, resp_illegal;
  logic [XLEN-1:0] resp_rdata;
  logic cfg_we = 1'b0;
  logic [VL_W-1:0] cfg_vl = '0;
  logic [XLEN-1:0] cfg_vtype = '0;

  always #4 clk = ~clk;  // 125 MHz

  vcsr_unit #(.XLEN(XLEN), .VLEN(VLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_src_i(req_src), .req_imm_i(req_imm),
    .backend_idle_i(backend_idle), .resp_valid_o(resp_valid), .resp_illegal_o(resp_illegal),
    .resp_rdata_o(resp_rdata), .cfg_we_i(cfg_we), .cfg_vl_i(cfg_vl), .cfg_vtype_i(cfg_vtype));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // scoreboard queues
  logic [XLEN:0] exp_q[$];
  string         tag_q[$];

  // bench model of the architectural state
  logic [XLEN-1:0] m_vstart = 0, m_vxrm = 0, m_vxsat = 0, m_vl = 0, m_vtype = 0;

  task automatic check(string tag, logic [XLEN:0] act, logic [XLEN:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected {illegal, rdata}, and model update
  function automatic logic [XLEN:0] predict(logic [2:0] op, logic [11:0] addr,
                                            logic [XLEN-1:0] src, logic [4:0] imm);
    logic [XLEN-1:0] opnd, old, nv;
    logic known, ro, wr, ill;
    opnd  = (op >= 3'd5) ? {{(XLEN-5){1'b0}}, imm} : src;
    known = 1'b1; ro = 1'b0;
    case (addr)
      12'h008: old = m_vstart;
      12'h009: old = m_vxsat;
      12'h00A: old = m_vxrm;
      12'hC20: begin old = m_vl;    ro = 1'b1; end
      12'hC21: begin old = m_vtype; ro = 1'b1; end
      12'hC22: begin old = VLEN / 8; ro = 1'b1; end
      default: begin old = 0; known = 1'b0; end
    endcase
    wr  = (op == 3'd1 || op == 3'd5) || (opnd != 0);
    ill = (op == 3'd0 || op == 3'd4) || !known || (ro && wr);
    if (!ill && wr) begin
      if (op == 3'd1 || op == 3'd5) nv = opnd;
      else if (op == 3'd2 || op == 3'd6) nv = old | opnd;
      else nv = old & ~opnd;
      case (addr)
        12'h008: m_vstart = nv % VLEN;
        12'h009: m_vxsat  = nv % 2;
        12'h00A: m_vxrm   = nv % 4;
        default: ;
      endcase
    end
    return {ill, ill ? {XLEN{1'b0}} : old};
  endfunction

  task automatic do_op(string tag, logic [2:0] op, logic [11:0] addr,
                       logic [XLEN-1:0] src, logic [4:0] imm, int delay);
    exp_q.push_back(predict(op, addr, src, imm));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_src = src; req_imm = imm;
    backend_idle = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < delay; i++) begin
      #1;
      check("R8 no response while backend busy", {1'b0, XLEN'(resp_valid)}, '0);
      check("R8 not ready while busy", {1'b0, XLEN'(req_ready)}, '0);
      @(negedge clk);
    end
    backend_idle = 1'b1;
    @(negedge clk);
    backend_idle = 1'b0;
  endtask

  task automatic cfg_write(logic [VL_W-1:0] vl, logic [XLEN-1:0] vt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_vl = vl; cfg_vtype = vt;
    @(negedge clk);
    cfg_we = 1'b0;
    m_vl = XLEN'(vl); m_vtype = vt;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (resp_valid) begin
        if (exp_q.size() == 0) check("unexpected response", 1, 0);
        else check(tag_q.pop_front(), {resp_illegal, resp_rdata}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 ready after reset", {1'b0, XLEN'(req_ready)}, {1'b0, XLEN'(1)});
    check("R1 no response after reset", {1'b0, XLEN'(resp_valid)}, '0);
    // R1 reset values via pure reads
    do_op("R1 vstart reset", 3'd6, 12'h008, 0, 0, 0);
    do_op("R1 vxrm reset", 3'd6, 12'h00A, 0, 0, 1);
    do_op("R1 vxsat reset", 3'd7, 12'h009, 0, 0, 0);
    do_op("R1 vl reset", 3'd2, 12'hC20, 0, 0, 2);
    do_op("R10 vlenb value", 3'd6, 12'hC22, 0, 0, 0);
    // R2 R3 R4 writes, sets, clears with truncation
    do_op("R4 vstart write truncated", 3'd1, 12'h008, 32'h1234_5A5, 0, 3);
    do_op("R3 vstart old value", 3'd2, 12'h008, 32'h0000_0102, 0, 0);
    do_op("R2 vstart set result", 3'd3, 12'h008, 32'h0000_00F0, 0, 1);
    do_op("R2 vstart clear result", 3'd6, 12'h008, 0, 0, 0);
    do_op("R4 vxrm imm write truncated", 3'd5, 12'h00A, 0, 5'd7, 0);
    do_op("R2 vxrm clear imm", 3'd7, 12'h00A, 0, 5'd1, 4);
    do_op("R3 vxrm read back", 3'd6, 12'h00A, 0, 0, 0);
    do_op("R4 vxsat set wide", 3'd2, 12'h009, 32'hFFFF_FFFE, 0, 0);
    do_op("R4 vxsat set bit0", 3'd6, 12'h009, 0, 5'd3, 0);
    do_op("R2 vxsat write zero", 3'd1, 12'h009, 0, 0, 2);
    do_op("R3 vxsat read", 3'd6, 12'h009, 0, 0, 0);
    // R9 configuration port
    cfg_write(9'd17, 32'h0000_0053);
    do_op("R9 vl after cfg", 3'd2, 12'hC20, 0, 0, 0);
    do_op("R9 vtype after cfg", 3'd7, 12'hC21, 0, 0, 1);
    // R5 refused writes leave state unchanged
    do_op("R5 write vl illegal", 3'd1, 12'hC20, 32'd3, 0, 0);
    do_op("R5 vl unchanged", 3'd6, 12'hC20, 0, 0, 0);
    do_op("R5 set vtype illegal", 3'd2, 12'hC21, 32'h80, 0, 2);
    do_op("R5 clear vlenb imm illegal", 3'd7, 12'hC22, 0, 5'd1, 0);
    do_op("R5 write-imm vtype zero illegal", 3'd5, 12'hC21, 0, 0, 0);
    do_op("R5 vtype unchanged", 3'd2, 12'hC21, 0, 0, 0);
    // R6 zero-operand set/clear on read-only
    do_op("R6 clear vl zero src", 3'd3, 12'hC20, 0, 0, 0);
    do_op("R6 set vlenb zero imm", 3'd6, 12'hC22, 0, 0, 1);
    // R7 unknown address and reserved op codes
    do_op("R7 unknown address", 3'd1, 12'h123, 32'd9, 0, 0);
    do_op("R7 op code 0", 3'd0, 12'h008, 32'h77, 0, 0);
    do_op("R7 op code 4", 3'd4, 12'h00A, 0, 5'd2, 1);
    do_op("R7 vstart unchanged", 3'd6, 12'h008, 0, 0, 0);
    do_op("R7 vxrm unchanged", 3'd6, 12'h00A, 0, 0, 0);
    // R8 long wait
    do_op("R8 long wait write", 3'd1, 12'h008, 32'd42, 0, 7);
    do_op("R8 long wait read", 3'd6, 12'h008, 0, 0, 5);
    repeat (3) @(negedge clk);
    check("R8 all responses seen", {1'b0, XLEN'(exp_q.size())}, '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule